// File: doc/BRIEF.md
# SMBus Status and Command Slave

This block is a two-wire management slave that listens on already synchronized SCL and SDA samples and pulls SDA low through an open-drain enable. It answers to one 7-bit address, held in a register that comes out of reset at a non-zero default and can be reloaded from a side input. It serves two transaction types.

A byte write brings a register selector and one data byte into a small write file: a host command register and two message bytes. A byte read sends a register selector, then a repeated start, then a read phase in which the slave shifts out one byte from a fixed, sparse status map. The status map is built from side-band inputs: power state, a 10-bit watchdog count, a set of event flags, two mailbox bytes, a watchdog status byte and seven calendar bytes. The block has no PEC, block transfers, clock stretching or master mode. The write file has no back-pressure: the bus cannot be held off, so each accepted write byte lands at once and the outputs are plain registers.

Top module: `smb_slave_target`

## Requirements
- R1: After reset the slave address is 7'h44 (parameter); a first byte whose upper 7 bits match it is ACKed (SDA low in the ninth clock), and a mismatch is NACKed and the rest of that transaction has no effect.
- R2: Once the address matches, the direction bit (bit 0 of the address byte) is ignored and the address is always ACKed, both in the first address byte and in the one after a repeated start.
- R3: A write is address, selector, data, stop. Selector 00h loads `host_cmd_o`, 04h loads `msg_byte0_o`, 05h loads `msg_byte1_o`; every other selector is ACKed but changes no output.
- R4: A write to a message byte always replaces its old value.
- R5: A read is address, selector, repeated start, address, then one data byte sent MSB first while the master clocks it; the byte is the map value captured when the selector is ACKed.
- R6: Selector 00h reads 00h. Selector 01h reads the power state in bits 2:0, where `pwr_state_i` code 0 reads 000, code 1 reads 100, code 2 reads 101 and code 3 reads 000; bits 7:3 are 0.
- R7: Selector 03h reads the watchdog count in bits 5:0, saturated to 3Fh whenever the count exceeds 3Fh; bits 7:6 are 0.
- R8: Selector 04h reads intruder in bit 0, temperature event in bit 1, processor-dead in bit 2, second timeout in bit 3, and in bit 7 the alert pin, forced to 1 while `alert_dis_i` is 1; bits 6:4 are 0.
- R9: Selectors 06h, 07h, 08h read mailbox A, mailbox B and the watchdog status byte; 09h through 0Fh read `rtc_i[0]` through `rtc_i[6]` (seconds, minutes, hours, weekday, day, month, year); 02h, 05h and 10h through FFh read 00h.
- R10: If SCL and SDA both stay high for IDLE_CYC (256) clocks inside a transaction, the slave returns to idle, releases SDA and ignores bits until the next start.
- R11: A pulse on `addr_ld_i` replaces the slave address with `addr_val_i`; afterwards only the new address is ACKed.
- R12: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_ld_i | input | 1 | Load new slave address |
| addr_val_i | input | 7 | New slave address |
| pwr_state_i | input | 2 | Power state code: 0 on, 1 hibernate, 2 off, 3 unknown |
| wdt_count_i | input | WDT_W | Watchdog count |
| intruder_i | input | 1 | Cover-open flag |
| temp_evt_i | input | 1 | Temperature event flag |
| cpu_dead_i | input | 1 | Processor-dead flag |
| second_to_i | input | 1 | Second watchdog timeout flag |
| alert_pin_i | input | 1 | Alert pin level |
| alert_dis_i | input | 1 | Alert pin disabled |
| mbox_a_i | input | 8 | Mailbox A byte |
| mbox_b_i | input | 8 | Mailbox B byte |
| wd_status_i | input | 8 | Watchdog status byte |
| rtc_i | input | 7x8 | Calendar bytes, index 0 seconds to 6 year |
| host_cmd_o | output | 8 | Host command register |
| msg_byte0_o | output | 8 | Message byte 0 |
| msg_byte1_o | output | 8 | Message byte 1 |

## Verification
A wrong protocol state shows up at the ninth clock of the byte it corrupts: a missing or extra ACK, or a data bit driven where the master drives, is visible on the bus within one byte time. A wrong map entry or saturation bound shows only in the data byte of a read to that selector, so the bench reads every implemented selector and the boundary counts 3Fh and 40h. A stuck timeout state shows as a write that lands after an abort, or as a later transaction that is never ACKed.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_CMD, ST_ACK_C,
    ST_WDATA, ST_ACK_D, ST_RDATA, ST_SKIP
  } link_st_e;

  typedef enum logic [1:0] {
    PWR_ON = 2'd0, PWR_HIB = 2'd1, PWR_OFF = 2'd2, PWR_UNK = 2'd3
  } pwr_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/smb_edge_detect.sv
module smb_edge_detect
  import smb_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o,
  output logic    both_high_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL is high marks a frame boundary
  assign ev_o.start  = scl_i & scl_q & sda_q & ~sda_i;
  assign ev_o.stop   = scl_i & scl_q & ~sda_q & sda_i;
  assign ev_o.rise   = scl_i & ~scl_q;
  assign ev_o.fall   = ~scl_i & scl_q;
  assign both_high_o = scl_i & sda_i;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int unsigned IDLE_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smb_read_map.sv
module smb_read_map
  import smb_tgt_pkg::*;
#(
  parameter int unsigned WDT_W    = 10,
  parameter int unsigned FIELD_W  = 6,
  parameter int unsigned RTC_N    = 7,
  parameter int unsigned RTC_BASE = 9
) (
  input  byte_t                   idx_i,
  input  logic [1:0]              pwr_i,
  input  logic [WDT_W-1:0]        wdt_i,
  input  logic                    intr_i,
  input  logic                    temp_i,
  input  logic                    dead_i,
  input  logic                    sec_to_i,
  input  logic                    alert_pin_i,
  input  logic                    alert_dis_i,
  input  byte_t                   mbox_a_i,
  input  byte_t                   mbox_b_i,
  input  byte_t                   wd_stat_i,
  input  logic [RTC_N-1:0][7:0]   rtc_i,
  output byte_t                   data_o
);
  localparam logic [WDT_W-1:0] SAT = WDT_W'((1 << FIELD_W) - 1);

  logic [FIELD_W-1:0] wdt_field;
  logic [2:0]         pcode;

  assign wdt_field = (wdt_i > SAT) ? SAT[FIELD_W-1:0] : wdt_i[FIELD_W-1:0];

  always_comb begin
    case (pwr_e'(pwr_i))
      PWR_HIB: pcode = 3'b100;
      PWR_OFF: pcode = 3'b101;
      default: pcode = 3'b000;
    endcase
  end

  always_comb begin
    data_o = '0;
    case (idx_i)
      8'h01: data_o = {5'b0, pcode};
      8'h03: data_o = BYTE_W'(wdt_field);
      8'h04: data_o = {alert_dis_i | alert_pin_i, 3'b000,
                       sec_to_i, dead_i, temp_i, intr_i};
      8'h06: data_o = mbox_a_i;
      8'h07: data_o = mbox_b_i;
      8'h08: data_o = wd_stat_i;
      default: data_o = '0;
    endcase
    for (int k = 0; k < RTC_N; k++) begin
      if (idx_i == 8'(RTC_BASE + k)) data_o = rtc_i[k];
    end
  end
endmodule

// File: rtl/smb_write_file.sv
module smb_write_file
  import smb_tgt_pkg::*;
#(
  parameter int unsigned MSG_N    = 2,
  parameter int unsigned MSG_BASE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  byte_t                 sel_i,
  input  byte_t                 data_i,
  output byte_t                 cmd_o,
  output logic [MSG_N-1:0][7:0] msg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cmd_o <= '0;
    else if (we_i && sel_i == 8'h00)    cmd_o <= data_i;
  end

  for (genvar g = 0; g < MSG_N; g++) begin : g_msg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   msg_o[g] <= '0;
      else if (we_i && sel_i == 8'(MSG_BASE + g))   msg_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/smb_slave_target.sv
module smb_slave_target
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0]  DEF_ADDR = 7'h44,
  parameter int unsigned WDT_W    = 10,
  parameter int unsigned IDLE_CYC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             addr_ld_i,
  input  logic [6:0]       addr_val_i,
  input  logic [1:0]       pwr_state_i,
  input  logic [WDT_W-1:0] wdt_count_i,
  input  logic             intruder_i,
  input  logic             temp_evt_i,
  input  logic             cpu_dead_i,
  input  logic             second_to_i,
  input  logic             alert_pin_i,
  input  logic             alert_dis_i,
  input  logic [7:0]       mbox_a_i,
  input  logic [7:0]       mbox_b_i,
  input  logic [7:0]       wd_status_i,
  input  logic [6:0][7:0]  rtc_i,
  output logic [7:0]       host_cmd_o,
  output logic [7:0]       msg_byte0_o,
  output logic [7:0]       msg_byte1_o
);
  localparam int unsigned MSG_N = 2;
  localparam logic [3:0]  LAST_BIT = 4'd8;

  bus_ev_t   ev;
  logic      both_high, tmo;
  link_st_e  st_q;
  logic [3:0] bitcnt_q;
  byte_t     shreg_q, txreg_q, sel_q, snap_q, map_byte;
  logic [6:0] addr_q;
  logic      cmd_seen_q, second_q, oe_q;
  logic      wr_en;
  logic [MSG_N-1:0][7:0] msg_w;
  logic      quiet;

  smb_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .ev_o(ev), .both_high_o(both_high)
  );

  smb_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .run_i(both_high && (st_q != ST_IDLE)), .expire_o(tmo)
  );

  smb_read_map #(.WDT_W(WDT_W)) u_map (
    .idx_i(shreg_q), .pwr_i(pwr_state_i), .wdt_i(wdt_count_i),
    .intr_i(intruder_i), .temp_i(temp_evt_i), .dead_i(cpu_dead_i),
    .sec_to_i(second_to_i), .alert_pin_i(alert_pin_i),
    .alert_dis_i(alert_dis_i), .mbox_a_i(mbox_a_i), .mbox_b_i(mbox_b_i),
    .wd_stat_i(wd_status_i), .rtc_i(rtc_i), .data_o(map_byte)
  );

  // no boundary or abort in this cycle: ordinary bit handling applies
  assign quiet = !tmo && !ev.stop && !ev.start;
  assign wr_en = quiet && ev.fall && (st_q == ST_WDATA) && (bitcnt_q == LAST_BIT);

  smb_write_file #(.MSG_N(MSG_N), .MSG_BASE(4)) u_wf (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .sel_i(sel_q),
    .data_i(shreg_q), .cmd_o(host_cmd_o), .msg_o(msg_w)
  );

  assign msg_byte0_o = msg_w[0];
  assign msg_byte1_o = msg_w[1];
  assign sda_oe_o    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= DEF_ADDR;
    else if (addr_ld_i) addr_q <= addr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      sel_q      <= '0;
      snap_q     <= '0;
      cmd_seen_q <= 1'b0;
      second_q   <= 1'b0;
      oe_q       <= 1'b0;
    end else if (tmo || ev.stop) begin
      st_q       <= ST_IDLE;
      oe_q       <= 1'b0;
      cmd_seen_q <= 1'b0;
    end else if (ev.start) begin
      st_q     <= ST_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
      second_q <= cmd_seen_q;
    end else begin
      if (ev.rise) begin
        if (st_q inside {ST_ADDR, ST_CMD, ST_WDATA}) begin
          shreg_q  <= {shreg_q[6:0], sda_i};
          bitcnt_q <= bitcnt_q + 4'd1;
        end else if (st_q == ST_RDATA) begin
          bitcnt_q <= bitcnt_q + 4'd1;
        end
      end
      if (ev.fall) begin
        case (st_q)
          ST_ADDR: if (bitcnt_q == LAST_BIT) begin
            // direction bit shreg_q[0] deliberately unused for the decision
            if (shreg_q[7:1] == addr_q) begin
              st_q <= ST_ACK_A;
              oe_q <= 1'b1;
            end else begin
              st_q       <= ST_SKIP;
              cmd_seen_q <= 1'b0;
            end
          end
          ST_ACK_A: begin
            bitcnt_q <= '0;
            if (second_q) begin
              st_q    <= ST_RDATA;
              txreg_q <= snap_q;
              oe_q    <= ~snap_q[7];
            end else begin
              st_q <= ST_CMD;
              oe_q <= 1'b0;
            end
          end
          ST_CMD: if (bitcnt_q == LAST_BIT) begin
            sel_q      <= shreg_q;
            snap_q     <= map_byte;
            oe_q       <= 1'b1;
            st_q       <= ST_ACK_C;
            cmd_seen_q <= 1'b1;
          end
          ST_ACK_C: begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            st_q     <= ST_WDATA;
          end
          ST_WDATA: if (bitcnt_q == LAST_BIT) begin
            oe_q       <= 1'b1;
            st_q       <= ST_ACK_D;
            cmd_seen_q <= 1'b0;
          end
          ST_ACK_D: begin
            oe_q <= 1'b0;
            st_q <= ST_SKIP;
          end
          ST_RDATA: begin
            if (bitcnt_q == LAST_BIT) begin
              oe_q <= 1'b0;
              st_q <= ST_SKIP;
            end else begin
              txreg_q <= {txreg_q[6:0], 1'b0};
              oe_q    <= ~txreg_q[6];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_slave_target_chk.sv
module smb_slave_target_chk #(
  parameter logic [6:0]  DEF_ADDR = 7'h44,
  parameter int unsigned WDT_W    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             tmo,
  input logic             idle_st,
  input logic             scl_fall,
  input logic [6:0]       addr_q,
  input logic [7:0]       map_idx,
  input logic [7:0]       map_byte,
  input logic             alert_dis,
  input logic [WDT_W-1:0] wdt,
  input logic [7:0]       msg0
);
  // R1: address register starts at its default
  a_r1_default_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (addr_q == DEF_ADDR));

  // R12: drive held while SCL stays high
  a_r12_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(sda_oe_o)) |-> sda_oe_o);

  // R12: no new drive while SCL stays high
  a_r12_no_new_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_oe_o)) |-> !sda_oe_o);

  // R10: timeout releases the bus and idles the link
  a_r10_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (!sda_oe_o && idle_st));

  // R7: saturation of the watchdog field
  a_r7_wdt_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx == 8'h03 && wdt > WDT_W'(63)) |-> (map_byte == 8'h3F));

  // R8: alert bit forced while disabled
  a_r8_alert_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx == 8'h04 && alert_dis) |-> map_byte[7]);

  // R4: message byte only updates right after an SCL fall
  a_r4_msg_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg0) |-> $past(scl_fall));
endmodule

bind smb_slave_target smb_slave_target_chk #(
  .DEF_ADDR(DEF_ADDR), .WDT_W(WDT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .tmo(tmo), .idle_st(st_q == smb_tgt_pkg::ST_IDLE), .scl_fall(ev.fall),
  .addr_q(addr_q), .map_idx(shreg_q), .map_byte(map_byte),
  .alert_dis(alert_dis_i), .wdt(wdt_count_i), .msg0(msg_byte0_o)
);

// File: tb/smb_slave_target_tb.sv
module smb_slave_target_tb_top;
  localparam int H = 6;
  localparam logic [6:0] DEF_A = 7'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic addr_ld = 1'b0;
  logic [6:0] addr_val = '0;
  logic [1:0] pwr = '0;
  logic [9:0] wdt = '0;
  logic intr = 0, temp = 0, dead = 0, sto = 0, apin = 0, adis = 0;
  logic [7:0] mba = '0, mbb = '0, wds = '0;
  logic [6:0][7:0] rtc = '0;
  logic [7:0] hcmd, m0, m1;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] e_cmd = 0, e_m0 = 0, e_m1 = 0;
  logic [6:0] cur_addr = DEF_A;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smb_slave_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_ld_i(addr_ld), .addr_val_i(addr_val), .pwr_state_i(pwr),
    .wdt_count_i(wdt), .intruder_i(intr), .temp_evt_i(temp),
    .cpu_dead_i(dead), .second_to_i(sto), .alert_pin_i(apin),
    .alert_dis_i(adis), .mbox_a_i(mba), .mbox_b_i(mbb),
    .wd_status_i(wds), .rtc_i(rtc), .host_cmd_o(hcmd),
    .msg_byte0_o(m0), .msg_byte1_o(m1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(1);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1; tick(H); scl_m = 1; tick(H / 2); b = sda_bus;
    tick(H - H / 2); scl_m = 0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(1'b1);
  endtask

  task automatic start_c;
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask

  task automatic stop_c;
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  task automatic do_write(input logic [6:0] a, input logic rw, input logic [7:0] c,
                          input logic [7:0] d, output logic ka, output logic kc, output logic kd);
    start_c; send_byte({a, rw}, ka); send_byte(c, kc); send_byte(d, kd); stop_c;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c, input logic rw1,
                         input logic rw2, output logic ka, output logic kb, output logic [7:0] d);
    logic kc;
    start_c; send_byte({a, rw1}, ka); send_byte(c, kc);
    start_c; send_byte({a, rw2}, kb); recv_byte(d); stop_c;
  endtask

  function automatic logic [7:0] exp_map(input logic [7:0] c);
    logic [7:0] r = 8'h00;
    case (c)
      8'h01: r = (pwr == 2'd1) ? 8'h04 : (pwr == 2'd2) ? 8'h05 : 8'h00;
      8'h03: r = (wdt > 10'd63) ? 8'h3F : {2'b00, wdt[5:0]};
      8'h04: r = {apin | adis, 3'b000, sto, dead, temp, intr};
      8'h06: r = mba;
      8'h07: r = mbb;
      8'h08: r = wds;
      default: if (c >= 8'h09 && c <= 8'h0F) r = rtc[c - 8'h09];
    endcase
    return r;
  endfunction

  task automatic shuffle;
    pwr = 2'($urandom); wdt = 10'($urandom); intr = 1'($urandom); temp = 1'($urandom);
    dead = 1'($urandom); sto = 1'($urandom); apin = 1'($urandom); adis = 1'($urandom);
    mba = 8'($urandom); mbb = 8'($urandom); wds = 8'($urandom);
    for (int k = 0; k < 7; k++) rtc[k] = 8'($urandom);
  endtask

  task automatic read_check(input logic [7:0] c, input string req);
    logic ka, kb; logic [7:0] d;
    do_read(cur_addr, c, 1'b0, 1'b1, ka, kb, d);
    chk(ka == 0 && kb == 0, req, {ka, kb}, 0);
    chk(d == exp_map(c), req, d, exp_map(c));
  endtask

  task automatic write_model(input logic [7:0] c, input logic [7:0] d);
    if (c == 8'h00) e_cmd = d;
    else if (c == 8'h04) e_m0 = d;
    else if (c == 8'h05) e_m1 = d;
  endtask

  task automatic outs_check(input string req);
    chk(hcmd == e_cmd && m0 == e_m0 && m1 == e_m1, req, {hcmd, m0, m1}, {e_cmd, e_m0, e_m1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic ka, kc, kd;
    logic [7:0] d;
    void'($urandom(32'h1bad5eed));
    tick(4); rst_n = 1; tick(4);

    // reset state
    chk(sda_oe == 0, "R12 reset oe", sda_oe, 0);
    outs_check("R3 reset outputs");

    // R1: default address ACKed, other NACKed and harmless
    do_write(DEF_A, 1'b0, 8'h00, 8'h5A, ka, kc, kd);
    write_model(8'h00, 8'h5A);
    chk({ka, kc, kd} == 3'b000, "R1 default addr acks", {ka, kc, kd}, 0);
    outs_check("R3 cmd write");
    do_write(7'h21, 1'b0, 8'h04, 8'h77, ka, kc, kd);
    chk(ka == 1, "R1 mismatch nack", ka, 1);
    outs_check("R1 mismatch no effect");

    // R2: direction bit set in write address still ACKed
    do_write(DEF_A, 1'b1, 8'h04, 8'h11, ka, kc, kd);
    write_model(8'h04, 8'h11);
    chk(ka == 0, "R2 rw ignored ack", ka, 0);
    outs_check("R2 rw ignored write");

    // R3/R4: message bytes, overwrite, reserved selector
    do_write(DEF_A, 1'b0, 8'h05, 8'hC3, ka, kc, kd); write_model(8'h05, 8'hC3);
    do_write(DEF_A, 1'b0, 8'h04, 8'h22, ka, kc, kd); write_model(8'h04, 8'h22);
    outs_check("R4 overwrite msg0");
    do_write(DEF_A, 1'b0, 8'h02, 8'hEE, ka, kc, kd);
    chk(kd == 0, "R3 reserved acked", kd, 0);
    outs_check("R3 reserved discarded");

    // R2: read with both direction bits inverted
    shuffle;
    do_read(cur_addr, 8'h06, 1'b1, 1'b0, ka, kc, d);
    chk(ka == 0 && kc == 0 && d == exp_map(8'h06), "R2 rw ignored read", d, exp_map(8'h06));

    // R6 power encodings
    read_check(8'h00, "R6 reg0");
    for (int p = 0; p < 4; p++) begin pwr = 2'(p); read_check(8'h01, "R6 power"); end

    // R7 saturation bounds
    wdt = 10'd63;   read_check(8'h03, "R7 wdt 3F");
    wdt = 10'd64;   read_check(8'h03, "R7 wdt 40");
    wdt = 10'd1023; read_check(8'h03, "R7 wdt max");
    wdt = 10'd5;    read_check(8'h03, "R7 wdt small");

    // R8 flag byte, alert forcing
    {intr, temp, dead, sto} = 4'b1010; apin = 0; adis = 1; read_check(8'h04, "R8 alert forced");
    {intr, temp, dead, sto} = 4'b0101; apin = 0; adis = 0; read_check(8'h04, "R8 alert low");
    apin = 1; read_check(8'h04, "R8 alert high");

    // R9 full sweep
    shuffle;
    for (int c = 2; c <= 8'h11; c++) read_check(8'(c), "R9 map");
    read_check(8'hFF, "R9 reserved top");

    // R5: inputs change after selector ACK do not alter the byte
    begin
      logic [7:0] want;
      mba = 8'h3C; want = 8'h3C;
      start_c; send_byte({cur_addr, 1'b0}, ka); send_byte(8'h06, kc);
      mba = 8'hC3;
      start_c; send_byte({cur_addr, 1'b1}, kd); recv_byte(d); stop_c;
      chk(d == want, "R5 snapshot at ack", d, want);
    end

    // R10 idle timeout mid-write
    start_c; send_byte({cur_addr, 1'b0}, ka); send_byte(8'h04, kc);
    sda_m = 1; tick(2); scl_m = 1; tick(300);
    chk(sda_oe == 0, "R10 released", sda_oe, 0);
    scl_m = 0; tick(H);
    send_byte(8'hA5, kd); stop_c;
    chk(kd == 1, "R10 ignored after abort", kd, 1);
    outs_check("R10 no write after abort");
    do_write(cur_addr, 1'b0, 8'h04, 8'h66, ka, kc, kd); write_model(8'h04, 8'h66);
    outs_check("R10 recovers");

    // R11 address reload
    @(negedge clk); addr_val = 7'h1B; addr_ld = 1; @(negedge clk); addr_ld = 0;
    do_write(DEF_A, 1'b0, 8'h05, 8'h99, ka, kc, kd);
    chk(ka == 1, "R11 old addr nack", ka, 1);
    cur_addr = 7'h1B;
    do_write(cur_addr, 1'b0, 8'h05, 8'h98, ka, kc, kd); write_model(8'h05, 8'h98);
    chk(ka == 0, "R11 new addr ack", ka, 0);
    outs_check("R11 new addr write");

    // random mix
    for (int n = 0; n < 60; n++) begin
      shuffle;
      if ($urandom_range(1, 0) == 0) begin
        logic [7:0] c = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'($urandom_range(16, 0));
        read_check(c, "R5 random read");
      end else begin
        logic [7:0] c, v;
        case ($urandom_range(3, 0))
          0: c = 8'h00; 1: c = 8'h04; 2: c = 8'h05; default: c = 8'($urandom);
        endcase
        v = 8'($urandom);
        do_write(cur_addr, 1'($urandom), c, v, ka, kc, kd); write_model(c, v);
        outs_check("R3 random write");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule